// File: doc/BRIEF.md
# SDIO Read-Wait Controller

This block is the part of an SD host data-path controller that pauses a card-to-host multi-block read. It runs on the card clock. It can hold off the card in one of two ways, chosen by `rw_mode`. In the D2 method it pulls data line D2 low for the length of the pause. It ends the pause with a single high cycle on D2 and then releases the line. In the clock-stop method it stops the card clock shortly after a block's end bit. The clock stays stopped until software raises the start request again.

The host-side data path supplies the control bits and three single-cycle progress strobes for each block: start bit seen, CRC received and end bit received. The block never cuts into a block that is being received. A pause request that arrives during a block takes effect once that block is complete. While a D2 pause is in force, `irq_win` tells the interrupt logic that it may sample D1 for card interrupts. Serial capture, CRC checking and the command path are handled elsewhere.

Top module: `sdio_rdwait_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is idle: `d2_oe`=0, `d2_out`=1, `ck_en`=1 and `irq_win`=0.
- R2: A pause can happen only while `dp_en`, `sdio_en` and `dir_rx` (1 = card to host) are all 1. With any of them at 0, `rw_start` has no effect on D2, `irq_win` or `ck_en`.
- R3: D2 method (`rw_mode`=0): when `rw_start`=1 and `rw_stop`=0 are sampled while idle or waiting for data, the pause begins at once, even before any block has arrived. For the first two cycles `irq_win`=1 and D2 is not driven. From the third cycle on, `d2_oe`=1 and `d2_out`=0.
- R4: When `rw_stop`=1 is sampled while D2 is held low, D2 stays low for two more cycles. It is then driven high (`d2_oe`=1, `d2_out`=1) for exactly one cycle, and then released.
- R5: After the stop sequence the block waits for data. A pause does not start again while `rw_stop`=1. Once `rw_stop` returns to 0, a pending `rw_start` starts a new pause.
- R6: A `blk_start` strobe starts block reception. A start request made during reception is deferred: in the D2 method, the pause begins in the cycle after `crc_done` is sampled.
- R7: `irq_win` is 1 during the two lead cycles, the low hold and the two stop cycles, and 0 at all other times, including the high cycle.
- R8: Clock-stop method (`rw_mode`=1): if `rw_start`=1 and `rw_stop`=0 when `end_bit` is sampled, `ck_en` stays 1 for two more cycles and then goes to 0. If `rw_start`=0 at `end_bit`, the clock keeps running.
- R9: A stopped clock restarts only after `rw_start` has been seen at 0 and then at 1 again.
- R10: Dropping `dp_en` (or `sdio_en` or `dir_rx`) returns the block to idle from any state. This releases D2, clears `irq_win` and restores `ck_en` to 1.
- R11: `ck_en` changes only on the falling edge of `clk`, and `card_clk` equals `clk` AND `ck_en`. A stopped card clock is therefore low during the high phase of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running card clock source |
| rst_n | input | 1 | Asynchronous reset, active low |
| dp_en | input | 1 | Data path enabled |
| sdio_en | input | 1 | SDIO-specific operation enabled |
| dir_rx | input | 1 | Transfer direction, 1 = card to host |
| rw_mode | input | 1 | 0 = D2 method, 1 = clock-stop method |
| rw_start | input | 1 | Read-wait start request |
| rw_stop | input | 1 | Read-wait stop request |
| blk_start | input | 1 | Strobe: block start bit seen |
| crc_done | input | 1 | Strobe: block CRC received |
| end_bit | input | 1 | Strobe: block end bit received |
| d2_out | output | 1 | Level driven on D2 |
| d2_oe | output | 1 | D2 output enable |
| ck_en | output | 1 | Glitch-free card clock enable |
| card_clk | output | 1 | Gated card clock |
| irq_win | output | 1 | D1 may be sampled for card interrupts |

## Verification
The D2 method is tried from three starting points: straight from idle before any block, after a completed stop with `rw_stop` still high, and with the request made in the middle of a block. Together these tell apart an immediate start, a start blocked by a pending stop, and a start deferred until the CRC. The clock-stop method is run with `rw_start` high and low at the end bit, which separates a requested stop from a clock that keeps running. It is also run with the request held high through the stop and then toggled, which shows that restart needs a fresh request. Disabling the path with one of the three enable conditions low, and dropping `dp_en` in the middle of a pause, separates the gating conditions from the forced return to idle.

// File: rtl/sdio_rdwait_ctrl.sv
module sdio_rdwait_ctrl #(
  parameter int LEAD_CYC = 2,
  parameter int STOP_CYC = 2,
  parameter int GATE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_en,
  input  logic sdio_en,
  input  logic dir_rx,
  input  logic rw_mode,
  input  logic rw_start,
  input  logic rw_stop,
  input  logic blk_start,
  input  logic crc_done,
  input  logic end_bit,
  output logic d2_out,
  output logic d2_oe,
  output logic ck_en,
  output logic card_clk,
  output logic irq_win
);
  localparam int MAXC = (LEAD_CYC > STOP_CYC) ?
                        ((LEAD_CYC > GATE_CYC) ? LEAD_CYC : GATE_CYC) :
                        ((STOP_CYC > GATE_CYC) ? STOP_CYC : GATE_CYC);
  localparam int CW = $clog2(MAXC) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_RX, S_LEAD, S_HOLD, S_STOP, S_PULSE, S_GATE, S_OFF
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic rel, ck_q;

  wire ok     = dp_en & sdio_en & dir_rx;
  wire arm    = rw_start & ~rw_stop;
  wire go_d2  = arm & ~rw_mode;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:  nxt = go_d2 ? S_LEAD : S_WAIT;
      S_WAIT:  if (blk_start) nxt = S_RX;
               else if (go_d2) nxt = S_LEAD;
      S_RX:    if (!rw_mode && crc_done) nxt = go_d2 ? S_LEAD : S_WAIT;
               else if (rw_mode && end_bit) nxt = arm ? S_GATE : S_WAIT;
      S_LEAD:  if (cnt == CW'(LEAD_CYC - 1)) nxt = S_HOLD;
      S_HOLD:  if (rw_stop) nxt = S_STOP;
      S_STOP:  if (cnt == CW'(STOP_CYC - 1)) nxt = S_PULSE;
      S_PULSE: nxt = S_WAIT;
      S_GATE:  if (cnt == CW'(GATE_CYC - 1)) nxt = S_OFF;
      S_OFF:   if (rel && rw_start) nxt = S_WAIT;
      default: nxt = S_IDLE;
    endcase
    if (!ok) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      rel <= 1'b0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? '0 : cnt + 1'b1;
      rel <= (st == S_OFF) ? (rel | ~rw_start) : 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= 1'b1;
    else        ck_q <= (st != S_OFF);
  end

  assign ck_en    = ck_q;
  assign card_clk = clk & ck_q;
  assign d2_oe    = (st == S_HOLD) || (st == S_STOP) || (st == S_PULSE);
  assign d2_out   = !((st == S_HOLD) || (st == S_STOP));
  assign irq_win  = (st == S_LEAD) || (st == S_HOLD) || (st == S_STOP);
endmodule

// File: rtl/sdio_rdwait_ctrl_chk.sv
module sdio_rdwait_ctrl_chk #(
  parameter int GATE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic dp_en,
  input logic sdio_en,
  input logic dir_rx,
  input logic end_bit,
  input logic d2_out,
  input logic d2_oe,
  input logic ck_en,
  input logic irq_win
);
  logic [7:0] since_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_end <= 8'hFF;
    else if (end_bit)        since_end <= 8'd0;
    else if (since_end != 8'hFF) since_end <= since_end + 8'd1;
  end

  p_gated_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dp_en && sdio_en && dir_rx) |-> (!d2_oe && !irq_win));

  p_lead_before_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d2_oe) |-> ($past(irq_win) && !$past(d2_oe) && !d2_out));

  p_single_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (d2_oe && d2_out) |=> !d2_oe);

  p_high_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (d2_oe && d2_out) |-> $past(d2_oe && !d2_out));

  p_window_not_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_win |-> !(d2_oe && d2_out));

  p_clock_stop_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ck_en) |-> (since_end == 8'(GATE_CYC)));

  p_release_on_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dp_en) && !$past(dp_en, 2)) |-> ck_en);
endmodule

bind sdio_rdwait_ctrl sdio_rdwait_ctrl_chk #(.GATE_CYC(GATE_CYC)) u_chk (.*);

// File: tb/sdio_rdwait_ctrl_test.sv
module sdio_rdwait_ctrl_test;
  localparam int PER = 10;
  localparam logic [3:0] C_I = 4'b0110;
  localparam logic [3:0] C_L = 4'b0111;
  localparam logic [3:0] C_H = 4'b1011;
  localparam logic [3:0] C_P = 4'b1110;
  localparam logic [3:0] C_O = 4'b0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp_en = 0, sdio_en = 0, dir_rx = 0, rw_mode = 0;
  logic rw_start = 0, rw_stop = 0, blk_start = 0, crc_done = 0, end_bit = 0;
  logic d2_out, d2_oe, ck_en, card_clk, irq_win;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] q_exp[$];
  string q_req[$];

  always #(PER/2) clk = ~clk;

  sdio_rdwait_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dp_en(dp_en), .sdio_en(sdio_en), .dir_rx(dir_rx),
    .rw_mode(rw_mode), .rw_start(rw_start), .rw_stop(rw_stop),
    .blk_start(blk_start), .crc_done(crc_done), .end_bit(end_bit),
    .d2_out(d2_out), .d2_oe(d2_oe), .ck_en(ck_en), .card_clk(card_clk),
    .irq_win(irq_win));

  // {d2_oe, d2_out, ck_en, irq_win} expected after the edge that samples the inputs just set
  task automatic step(input logic [3:0] e, input string req);
    @(negedge clk);
    q_exp.push_back(e);
    q_req.push_back(req);
  endtask

  task automatic chk_gate(input logic e, input string req);
    @(posedge clk);
    #1;
    checks++;
    if (card_clk !== e) begin
      fails++;
      $display("FAIL %s: card_clk actual %b expected %b", req, card_clk, e);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(PER/4);
      while (q_exp.size() > 0) begin
        logic [3:0] e, a;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        a = {d2_oe, d2_out, ck_en, irq_win};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: {oe,d2,cken,irq} actual %b expected %b at %0t", r, a, e, $time);
        end
      end
    end
  end

  initial begin
    #(PER*20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(C_I, "R1"); step(C_I, "R1");
    rst_n = 1'b1;
    // R2: each enable condition missing in turn
    dp_en = 1; sdio_en = 1; dir_rx = 0; rw_start = 1;
    step(C_I, "R2"); step(C_I, "R2"); step(C_I, "R2");
    sdio_en = 0; dir_rx = 1;
    step(C_I, "R2"); step(C_I, "R2");
    // R3/R7: straight from idle
    sdio_en = 1;
    step(C_L, "R3 R7"); step(C_L, "R3 R7"); step(C_H, "R3"); step(C_H, "R3");
    // R4: stop sequence
    rw_stop = 1;
    step(C_H, "R4 R7"); step(C_H, "R4"); step(C_P, "R4 R7"); step(C_I, "R4");
    // R5: stop left set blocks re-entry
    step(C_I, "R5"); step(C_I, "R5");
    rw_stop = 0;
    step(C_L, "R5"); step(C_L, "R5"); step(C_H, "R5");
    // R10: drop enable mid pause
    dp_en = 0;
    step(C_I, "R10");
    rw_start = 0;
    step(C_I, "R10");
    // R6: deferral until CRC
    dp_en = 1;
    step(C_I, "R6");
    blk_start = 1; step(C_I, "R6");
    blk_start = 0; rw_start = 1;
    step(C_I, "R6"); step(C_I, "R6");
    crc_done = 1; step(C_L, "R6");
    crc_done = 0; step(C_L, "R6"); step(C_H, "R6");
    rw_stop = 1;
    step(C_H, "R4"); step(C_H, "R4"); step(C_P, "R4"); step(C_I, "R4");
    rw_start = 0; rw_stop = 0;
    step(C_I, "R5");
    // R8/R9: clock-stop method
    rw_mode = 1;
    blk_start = 1; step(C_I, "R8");
    blk_start = 0; rw_start = 1; step(C_I, "R8");
    end_bit = 1; step(C_I, "R8");
    end_bit = 0; step(C_I, "R8"); step(C_O, "R8");
    chk_gate(1'b0, "R11");
    step(C_O, "R9"); step(C_O, "R9");
    rw_start = 0; step(C_O, "R9");
    rw_start = 1; step(C_I, "R9");
    chk_gate(1'b1, "R11");
    // R8: no request at end bit keeps clock running
    rw_start = 0; blk_start = 1; step(C_I, "R8");
    blk_start = 0; end_bit = 1; step(C_I, "R8");
    end_bit = 0; step(C_I, "R8"); step(C_I, "R8"); step(C_I, "R8");
    // R10: drop enable while clock is stopped
    rw_start = 1; blk_start = 1; step(C_I, "R10");
    blk_start = 0; end_bit = 1; step(C_I, "R10");
    end_bit = 0; step(C_I, "R10"); step(C_O, "R10");
    dp_en = 0; step(C_I, "R10");
    chk_gate(1'b1, "R11");
    step(C_I, "R10");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule